// File: doc/BRIEF.md
# JTAG Chain Router

This block sits between two possible JTAG masters and a scan chain made of an on-board target device and an optional plug-in card. One master is the host CPU, which toggles TCK, TMS and TDI by writing a control register and reads TDO back from it. The other master is an external debugger on a header. When the debugger is sensed, the block releases its own drivers on the shared clock, mode, reset and debug lines. It still steers the TDI/TDO path, so the debugger sees the same chain the CPU would.

Chain topology follows an active-low card-present input. With no card fitted, master TDI goes straight to the target device. With a card fitted, master TDI enters the card first and the card's TDO feeds the target, so the card is first in the chain. In both cases the chain output is the target's TDO. Both sense inputs pass through synchronizers. The topology changes only while the synchronized TCK line is low, so a switch cannot produce a partial clock edge in the chain. A second register drives the target's reset and debug-request lines.

Top module: `jtagChainRouter`

## Requirements
- R1: After reset, tckOut=0, tmsOut=0, tgtResetN=1, tgtDebugN=1, the chain is in its no-card topology, drvEn=1 (no debugger sensed) and the CPU TDI bit is 0.
- R2: A write with regSel=0 loads the chain control register. wrData bit 0 sets tckOut, bit 1 sets tmsOut and bit 2 sets the CPU TDI, all visible the cycle after the write edge.
- R3: With regSel=0, rdData returns the three stored bits in positions 0 to 2 and the current target TDO (devTdo) in bit 3, with all higher bits zero. hdrTdo always equals devTdo.
- R4: A write with regSel=1 loads the debug register. Bit 0 = 1 drives tgtResetN low and bit 1 = 1 drives tgtDebugN low. With regSel=1, rdData returns those two bits in positions 0 and 1, with higher bits zero.
- R5: In the no-card topology, devTdi equals the master TDI and cardTdi is held at 1.
- R6: In the card topology, cardTdi equals the master TDI and devTdi equals cardTdo.
- R7: When hdrSenseN is held low, drvEn goes to 0 within SYNC_STAGES+1 cycles and the master TDI becomes hdrTdi. When hdrSenseN returns high, drvEn returns to 1 and the master TDI becomes the CPU TDI bit again.
- R8: A change of cardPresentN changes the topology only while lineTck is low. While lineTck stays high, the old topology is kept.
- R9: While the debugger owns the lines, the topology still follows cardPresentN.
- R10: A write to one register leaves the other register's contents and pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the chain control register, 1 selects the debug register |
| wrData | input | REG_W | Write data |
| rdData | output | REG_W | Read data of the selected register |
| cardPresentN | input | 1 | Card fitted, active low, asynchronous |
| hdrSenseN | input | 1 | Debugger attached, active low, asynchronous |
| lineTck | input | 1 | Observed level of the shared TCK line |
| hdrTdi | input | 1 | TDI from the debugger header |
| hdrTdo | output | 1 | Chain TDO returned to the header |
| devTdi | output | 1 | TDI into the target device |
| devTdo | input | 1 | TDO from the target device |
| cardTdi | output | 1 | TDI into the card |
| cardTdo | input | 1 | TDO from the card |
| tckOut | output | 1 | CPU-driven TCK value |
| tmsOut | output | 1 | CPU-driven TMS value |
| tgtResetN | output | 1 | Target reset line value, active low |
| tgtDebugN | output | 1 | Target debug-request line value, active low |
| drvEn | output | 1 | Output enable for tckOut, tmsOut, tgtResetN and tgtDebugN |

## Verification
The assertions check on every cycle that the card-first path and the parked card input match the registered topology, and that drvEn is the inverse of debugger ownership. They also check that a topology change is preceded by a low synchronized TCK, and that register writes reach the pins on the next cycle. Some behaviour needs whole scenarios and only the bench shows it. This covers the latency from a sense-pin change to a routing change, a topology held while TCK is high and then taken once TCK falls, and routing that follows the card while the debugger owns the lines. It also covers readback of the live TDO and the isolation between the two registers.

// File: rtl/jtagRoutePkg.sv
package jtagRoutePkg;

  // chain control register bit positions
  localparam int CHAIN_TCK_BIT = 0;
  localparam int CHAIN_TMS_BIT = 1;
  localparam int CHAIN_TDI_BIT = 2;
  localparam int CHAIN_TDO_BIT = 3;

  // debug register bit positions
  localparam int DBG_RESET_BIT = 0;
  localparam int DBG_HALT_BIT  = 1;

  localparam int CHAIN_BITS = 3;
  localparam int DBG_BITS   = 2;

  typedef struct packed {
    logic cardInChain;  // registered topology: card sits ahead of target
    logic hdrOwns;      // external debugger owns the shared lines
    logic chainWr;      // write strobe, chain control register
    logic dbgWr;        // write strobe, debug register
  } routeStrobes_t;

endpackage

// File: rtl/syncBank.sv
module syncBank #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= RST_VAL;
    else       stage[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[i] <= RST_VAL;
      else       stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/jtagRouteCtrl.sv
module jtagRouteCtrl
  import jtagRoutePkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic          regSel,
  input  logic          cardPresentN,
  input  logic          hdrSenseN,
  input  logic          lineTck,
  output routeStrobes_t strobes
);

  localparam int SENSE_W = 3;
  // reset image: tck low, debugger absent, card absent
  localparam logic [SENSE_W-1:0] SENSE_RST = 3'b011;

  logic [SENSE_W-1:0] senseRaw;
  logic [SENSE_W-1:0] senseSync;
  logic               tckSyncd;
  logic               hdrSyncN;
  logic               cardSyncN;
  logic               cardInChain;
  logic               hdrOwns;

  assign senseRaw = {lineTck, hdrSenseN, cardPresentN};

  syncBank #(
    .WIDTH  (SENSE_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SENSE_RST)
  ) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (senseRaw),
    .dout(senseSync)
  );

  assign tckSyncd  = senseSync[2];
  assign hdrSyncN  = senseSync[1];
  assign cardSyncN = senseSync[0];

  // drivers are released as soon as the debugger is seen; no TCK gating,
  // otherwise a CPU holding TCK high would block the handover
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hdrOwns <= 1'b0;
    else       hdrOwns <= !hdrSyncN;
  end

  // topology follows the card only while the chain clock is quiet
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cardInChain <= 1'b0;
    else if (!tckSyncd && (cardInChain != !cardSyncN))
      cardInChain <= !cardSyncN;
  end

  always_comb begin
    strobes.cardInChain = cardInChain;
    strobes.hdrOwns     = hdrOwns;
    strobes.chainWr     = regWrEn && !regSel;
    strobes.dbgWr       = regWrEn && regSel;
  end

endmodule

// File: rtl/jtagRouteDp.sv
module jtagRouteDp
  import jtagRoutePkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  routeStrobes_t    strobes,
  input  logic             regSel,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             hdrTdi,
  output logic             hdrTdo,
  output logic             devTdi,
  input  logic             devTdo,
  output logic             cardTdi,
  input  logic             cardTdo,
  output logic             tckOut,
  output logic             tmsOut,
  output logic             tgtResetN,
  output logic             tgtDebugN,
  output logic             drvEn
);

  logic [CHAIN_BITS-1:0] chainBits;
  logic [DBG_BITS-1:0]   dbgBits;
  logic                  masterTdi;
  logic                  unusedWrHi;

  assign unusedWrHi = ^wrData[REG_W-1:CHAIN_BITS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                chainBits <= '0;
    else if (strobes.chainWr) chainBits <= wrData[CHAIN_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dbgBits <= '0;
    else if (strobes.dbgWr) dbgBits <= wrData[DBG_BITS-1:0];
  end

  // pin values; the enable decides who actually drives the lines
  assign tckOut    = chainBits[CHAIN_TCK_BIT];
  assign tmsOut    = chainBits[CHAIN_TMS_BIT];
  assign tgtResetN = !dbgBits[DBG_RESET_BIT];
  assign tgtDebugN = !dbgBits[DBG_HALT_BIT];
  assign drvEn     = !strobes.hdrOwns;

  // TDI steering
  assign masterTdi = strobes.hdrOwns ? hdrTdi : chainBits[CHAIN_TDI_BIT];

  always_comb begin
    if (strobes.cardInChain) begin
      cardTdi = masterTdi;
      devTdi  = cardTdo;
    end else begin
      cardTdi = 1'b1;
      devTdi  = masterTdi;
    end
  end

  // the target is last in the chain in both topologies
  assign hdrTdo = devTdo;

  always_comb begin
    rdData = '0;
    if (regSel) begin
      rdData[DBG_BITS-1:0] = dbgBits;
    end else begin
      rdData[CHAIN_BITS-1:0] = chainBits;
      rdData[CHAIN_TDO_BIT]  = devTdo;
    end
  end

endmodule

// File: rtl/jtagChainRouter.sv
module jtagChainRouter
  import jtagRoutePkg::*;
#(
  parameter int REG_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             cardPresentN,
  input  logic             hdrSenseN,
  input  logic             lineTck,
  input  logic             hdrTdi,
  output logic             hdrTdo,
  output logic             devTdi,
  input  logic             devTdo,
  output logic             cardTdi,
  input  logic             cardTdo,
  output logic             tckOut,
  output logic             tmsOut,
  output logic             tgtResetN,
  output logic             tgtDebugN,
  output logic             drvEn
);

  routeStrobes_t strobes;

  jtagRouteCtrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regSel      (regSel),
    .cardPresentN(cardPresentN),
    .hdrSenseN   (hdrSenseN),
    .lineTck     (lineTck),
    .strobes     (strobes)
  );

  jtagRouteDp #(
    .REG_W(REG_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regSel   (regSel),
    .wrData   (wrData),
    .rdData   (rdData),
    .hdrTdi   (hdrTdi),
    .hdrTdo   (hdrTdo),
    .devTdi   (devTdi),
    .devTdo   (devTdo),
    .cardTdi  (cardTdi),
    .cardTdo  (cardTdo),
    .tckOut   (tckOut),
    .tmsOut   (tmsOut),
    .tgtResetN(tgtResetN),
    .tgtDebugN(tgtDebugN),
    .drvEn    (drvEn)
  );

endmodule

// File: rtl/jtagRouteChk.sv
module jtagRouteChk
  import jtagRoutePkg::*;
#(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input routeStrobes_t    strobes,
  input logic             tckSyncd,
  input logic [REG_W-1:0] wrData,
  input logic             devTdi,
  input logic             cardTdi,
  input logic             cardTdo,
  input logic             tckOut,
  input logic             tmsOut,
  input logic             tgtResetN,
  input logic             tgtDebugN,
  input logic             drvEn
);

  // R8: topology moves only after a low synchronized TCK
  a_r8_switch_tck_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(strobes.cardInChain) |-> !$past(tckSyncd));

  // R6: card ahead of target
  a_r6_card_first: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cardInChain |-> (devTdi == cardTdo));

  // R5: card input parked when it is not in the chain
  a_r5_card_parked: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.cardInChain |-> cardTdi);

  // R7: drivers released while the debugger owns the lines
  a_r7_release: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hdrOwns |-> !drvEn);

  a_r7_reclaim: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.hdrOwns |-> drvEn);

  // R2: chain register write reaches the pins next cycle
  a_r2_chain_pins: assert property (@(posedge clk) disable iff (!rstN)
    strobes.chainWr |=> (tckOut == $past(wrData[CHAIN_TCK_BIT])) &&
                        (tmsOut == $past(wrData[CHAIN_TMS_BIT])));

  // R4: debug register write reaches the reset and debug lines next cycle
  a_r4_dbg_pins: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dbgWr |=> (tgtResetN == !$past(wrData[DBG_RESET_BIT])) &&
                      (tgtDebugN == !$past(wrData[DBG_HALT_BIT])));

  // R10: a debug write leaves the chain pins alone
  a_r10_chain_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dbgWr |=> $stable(tckOut) && $stable(tmsOut));

endmodule

bind jtagChainRouter jtagRouteChk #(.REG_W(REG_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .strobes  (strobes),
  .tckSyncd (uCtrl.tckSyncd),
  .wrData   (wrData),
  .devTdi   (devTdi),
  .cardTdi  (cardTdi),
  .cardTdo  (cardTdo),
  .tckOut   (tckOut),
  .tmsOut   (tmsOut),
  .tgtResetN(tgtResetN),
  .tgtDebugN(tgtDebugN),
  .drvEn    (drvEn)
);

// File: tb/sim_jtagChainRouter.sv
module sim_jtagChainRouter;

  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0;
  logic             regSel = 1'b0;
  logic [REG_W-1:0] wrData = '0;
  logic [REG_W-1:0] rdData;
  logic             cardPresentN = 1'b1;
  logic             hdrSenseN = 1'b1;
  logic             dbgTck = 1'b0;
  logic             lineTck;
  logic             hdrTdi = 1'b0;
  logic             hdrTdo;
  logic             devTdi;
  logic             devTdo = 1'b0;
  logic             cardTdi;
  logic             cardTdo = 1'b0;
  logic             tckOut;
  logic             tmsOut;
  logic             tgtResetN;
  logic             tgtDebugN;
  logic             drvEn;

  int total = 0;
  int bad = 0;

  // shared TCK line: whoever drives it
  assign lineTck = drvEn ? tckOut : dbgTck;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtagChainRouter #(.REG_W(REG_W)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .cardPresentN(cardPresentN),
    .hdrSenseN(hdrSenseN), .lineTck(lineTck), .hdrTdi(hdrTdi),
    .hdrTdo(hdrTdo), .devTdi(devTdi), .devTdo(devTdo), .cardTdi(cardTdi),
    .cardTdo(cardTdo), .tckOut(tckOut), .tmsOut(tmsOut),
    .tgtResetN(tgtResetN), .tgtDebugN(tgtDebugN), .drvEn(drvEn)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {devTdi, cardTdi}
  function automatic logic [1:0] expTdi(input logic card, input logic hdr,
                                        input logic cpuTdi, input logic dbgTdi,
                                        input logic cTdo);
    logic m;
    m = hdr ? dbgTdi : cpuTdi;
    return card ? {cTdo, m} : {m, 1'b1};
  endfunction

  function automatic logic [REG_W-1:0] expChainRd(input logic [2:0] bits, input logic tdo);
    logic [REG_W-1:0] v;
    v = '0;
    v[2:0] = bits;
    v[3] = tdo;
    return v;
  endfunction

  task automatic wrReg(input logic sel, input logic [REG_W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; wrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [2:0] cpuBits = '0;
  logic [1:0] dbgBitsExp = '0;

  task automatic randomRound(input string req, input logic card, input logic hdr, input int n);
    for (int i = 0; i < n; i++) begin
      logic [REG_W-1:0] d;
      logic [1:0] e;
      d = REG_W'($urandom);
      d[0] = 1'b0;             // keep TCK low so routing stays settled
      devTdo  = 1'($urandom);
      cardTdo = 1'($urandom);
      hdrTdi  = 1'($urandom);
      wrReg(1'b0, d);
      cpuBits = d[2:0];
      regSel = 1'b0;
      #1;
      e = expTdi(card, hdr, cpuBits[2], hdrTdi, cardTdo);
      chk({req, " devTdi"}, int'(devTdi), int'(e[1]));
      chk({req, " cardTdi"}, int'(cardTdi), int'(e[0]));
      chk("R2 tmsOut", int'(tmsOut), int'(cpuBits[1]));
      chk("R3 rdData", int'(rdData), int'(expChainRd(cpuBits, devTdo)));
      chk("R3 hdrTdo", int'(hdrTdo), int'(devTdo));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 tckOut", int'(tckOut), 0);
    chk("R1 tmsOut", int'(tmsOut), 0);
    chk("R1 tgtResetN", int'(tgtResetN), 1);
    chk("R1 tgtDebugN", int'(tgtDebugN), 1);
    chk("R1 drvEn", int'(drvEn), 1);
    chk("R1 cardTdi", int'(cardTdi), 1);
    chk("R1 devTdi", int'(devTdi), 0);

    // R2 TCK bit
    wrReg(1'b0, 8'h01);
    chk("R2 tckOut", int'(tckOut), 1);
    wrReg(1'b0, 8'h00);
    chk("R2 tckOut low", int'(tckOut), 0);

    // R4 debug register and R10 isolation
    wrReg(1'b0, 8'h06);
    cpuBits = 3'b110;
    wrReg(1'b1, 8'hFD);
    dbgBitsExp = 2'b01;
    chk("R4 tgtResetN", int'(tgtResetN), 0);
    chk("R4 tgtDebugN", int'(tgtDebugN), 1);
    regSel = 1'b1; #1;
    chk("R4 readback", int'(rdData), 1);
    chk("R10 tmsOut kept", int'(tmsOut), 1);
    regSel = 1'b0; devTdo = 1'b0; #1;
    chk("R10 chain kept", int'(rdData), int'(expChainRd(cpuBits, 1'b0)));
    wrReg(1'b0, 8'h00);
    cpuBits = '0;
    regSel = 1'b1; #1;
    chk("R10 debug kept", int'(rdData), int'(dbgBitsExp));
    wrReg(1'b1, 8'h02);
    chk("R4 tgtDebugN", int'(tgtDebugN), 0);
    chk("R4 tgtResetN", int'(tgtResetN), 1);
    wrReg(1'b1, 8'h00);

    // R5 no card, random
    randomRound("R5", 1'b0, 1'b0, 30);

    // R6 card fitted with TCK low
    cardPresentN = 1'b0;
    idle(5);
    randomRound("R6", 1'b1, 1'b0, 30);

    // R8 removal with TCK high is held
    wrReg(1'b0, 8'h01);
    cpuBits = 3'b001;
    cardTdo = 1'b1; devTdo = 1'b0;
    cardPresentN = 1'b1;
    idle(8);
    chk("R8 held devTdi", int'(devTdi), 1);
    chk("R8 held cardTdi", int'(cardTdi), 0);
    wrReg(1'b0, 8'h00);
    cpuBits = '0;
    idle(5);
    #1;
    chk("R8 after tck low cardTdi", int'(cardTdi), 1);
    chk("R8 after tck low devTdi", int'(devTdi), 0);

    // R7 debugger attach
    hdrSenseN = 1'b0;
    dbgTck = 1'b0;
    idle(4);
    chk("R7 drvEn", int'(drvEn), 0);
    randomRound("R7", 1'b0, 1'b1, 20);

    // R9 card routing under debugger
    cardPresentN = 1'b0;
    idle(5);
    randomRound("R9", 1'b1, 1'b1, 20);

    // R8 under debugger: TCK high holds, low releases
    dbgTck = 1'b1;
    cardPresentN = 1'b1;
    hdrTdi = 1'b0; cardTdo = 1'b1;
    idle(8);
    chk("R8 dbg held devTdi", int'(devTdi), 1);
    dbgTck = 1'b0;
    idle(5);
    #1;
    chk("R9 dbg removed cardTdi", int'(cardTdi), 1);
    chk("R9 dbg removed devTdi", int'(devTdi), 0);

    // R7 detach
    hdrSenseN = 1'b1;
    idle(4);
    chk("R7 drvEn back", int'(drvEn), 1);
    randomRound("R7 reclaim", 1'b0, 1'b0, 10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule